// File: doc/BRIEF.md
# Interrupt Recognition Timing Sequencer

This block is a cycle-level timing model of the way a small 8-bit processor decides when to accept a level-sensitive maskable interrupt. It reads a stream of instruction descriptors, one per instruction. Each descriptor gives a length, or for a conditional branch whether it is taken and whether it crosses a page. It marks every clock cycle as an opcode fetch, an execution cycle or an interrupt-entry cycle. It does not decode opcodes and holds no registers or memory. It only counts cycles and decides where the request line is sampled.

Each instruction has one polling cycle. For most instructions that is the cycle before the last one. A request that is active and unmasked there is serviced once the instruction ends. A request that appears later waits for the next instruction's polling cycle. A taken branch that stays inside its page polls only in its first cycle. A request that first shows up in its second cycle therefore rides through the whole following instruction. Interrupt entry takes a fixed run of cycles before the handler's first fetch. On that cycle the block raises a one-cycle strobe and presents the measured request latency.

The descriptor is read combinationally during the cycle the block marks as a fetch. The driver moves to the next descriptor after each fetch cycle.

Top module: `irq_poll_seq`

## Requirements
- R1: After synchronous active-low reset the first cycle is an opcode fetch (`phase` = 0) and `hnd_start` is low.
- R2: `phase` is 0 in the first cycle of every instruction, 1 in its remaining cycles, and 2 during interrupt entry.
- R3: A non-branch descriptor (`ins_branch` = 0) lasts `ins_len` cycles, with values below 2 taken as 2 and above 8 taken as 8. A branch lasts 2 cycles when not taken, 3 when taken in-page and 4 when taken across a page.
- R4: `poll` is high in exactly one cycle per instruction. That is cycle N-1 of an N-cycle non-branch or page-crossing taken branch, and cycle 1 of a not-taken branch.
- R5: A taken in-page branch polls only in its first cycle. A request first seen in its second cycle is serviced only after the following instruction completes.
- R6: A request that is high with `irq_dis` low in a polling cycle is serviced at the end of that instruction. Otherwise the next polling cycle decides.
- R7: After the serviced instruction's last cycle, `phase` is 2 for exactly 7 cycles. Then a fetch cycle follows with `hnd_start` high for that single cycle.
- R8: With `hnd_start`, `hnd_lat` equals the number of cycles from the first cycle `irq` was high through the serviced instruction's last cycle, inclusive. It saturates at all ones.
- R9: While `irq_dis` is high at a polling cycle the request is not taken but stays pending. It is taken at the first polling cycle with `irq_dis` low, and latency still counts from the request's first cycle.
- R10: If `irq` falls before a polling cycle takes it, the measurement is dropped and a later rise starts afresh. Once taken, `irq` may fall without effect on the entry or the reported latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_len | input | 4 | Cycle count of a non-branch instruction |
| ins_branch | input | 1 | Descriptor is a conditional branch |
| ins_taken | input | 1 | Branch is taken |
| ins_cross | input | 1 | Taken branch lands in another page |
| irq | input | 1 | Level-sensitive interrupt request |
| irq_dis | input | 1 | Interrupt-disable flag |
| phase | output | 2 | 0 fetch, 1 execute, 2 interrupt entry |
| poll | output | 1 | Current cycle is the instruction's polling point |
| hnd_start | output | 1 | First cycle of the handler |
| hnd_lat | output | 8 | Request latency, valid with hnd_start |

## Verification
Two things can fall in one cycle: the request's first cycle can be the polling cycle itself, so latency measurement starts on the same edge that commits the request. Separately, the disable flag can clear exactly on a polling cycle. Directed cases place the request rise on polling cycles of 2-cycle, 7-cycle and branch instructions, and random cases place rises and disable windows anywhere. Each case is judged by the handler cycle number and by `hnd_lat` against a schedule that the bench builds from the descriptor lengths and polling rules.

// File: rtl/irqseq_pkg.sv
// Shared types and constants for the interrupt recognition sequencer.
// Assumes: phase codes are seen by the driver and must stay fixed.
package irqseq_pkg;
    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_EXEC  = 2'd1,
        PH_ENTRY = 2'd2
    } phase_e;

    localparam int ENTRY_CYC = 7;
    localparam int MIN_LEN   = 2;
    localparam int MAX_LEN   = 8;
endpackage

// File: rtl/irqseq_len_decode.sv
// Turns one instruction descriptor into an effective cycle count and the
// index (1-based) of its polling cycle.
// Assumes: MAX_LEN fits in LEN_W bits and is at least 4.
module irqseq_len_decode #(
    parameter int LEN_W   = 4,
    parameter int MIN_LEN = irqseq_pkg::MIN_LEN,
    parameter int MAX_LEN = irqseq_pkg::MAX_LEN,
    parameter int CW      = $clog2(MAX_LEN + 1)
) (
    input  logic [LEN_W-1:0] ins_len,
    input  logic             ins_branch,
    input  logic             ins_taken,
    input  logic             ins_cross,
    output logic [CW-1:0]    eff_len,
    output logic [CW-1:0]    poll_idx
);
    // Length and polling point from descriptor class.
    always_comb begin
        if (ins_branch) begin
            if (!ins_taken) begin
                eff_len  = CW'(2);
                poll_idx = CW'(1);
            end else if (!ins_cross) begin
                eff_len  = CW'(3);
                poll_idx = CW'(1);
            end else begin
                eff_len  = CW'(4);
                poll_idx = CW'(3);
            end
        end else begin
            if (int'(ins_len) < MIN_LEN)
                eff_len = CW'(MIN_LEN);
            else if (int'(ins_len) > MAX_LEN)
                eff_len = CW'(MAX_LEN);
            else
                eff_len = CW'(ins_len);
            poll_idx = eff_len - CW'(1);
        end
    end
endmodule

// File: rtl/irqseq_cycle_ctrl.sv
// Cycle sequencer: walks each instruction cycle by cycle, samples the
// request at the polling cycle, and runs the interrupt-entry sequence.
// Assumes: descriptor inputs are valid in every fetch cycle.
module irqseq_cycle_ctrl
    import irqseq_pkg::*;
#(
    parameter int CW        = 4,
    parameter int ENTRY_LEN = irqseq_pkg::ENTRY_CYC,
    localparam int EW       = $clog2(ENTRY_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] dec_len,
    input  logic [CW-1:0] dec_poll,
    input  logic          irq,
    input  logic          irq_dis,
    output phase_e        ph,
    output logic          poll_now,
    output logic          committed,
    output logic          hnd_start
);
    phase_e        ph_q;
    logic [CW-1:0] cyc_q;
    logic [CW-1:0] len_q;
    logic [CW-1:0] pollix_q;
    logic          commit_q;
    logic [EW-1:0] ent_q;
    logic          hnd_q;

    logic [CW-1:0] cur_len;
    logic [CW-1:0] cur_poll;
    logic [CW-1:0] cur_idx;
    logic          in_instr;
    logic          last_now;
    logic          take_now;

    // Current instruction view: live decode on fetch, stored copy after.
    always_comb begin
        in_instr = (ph_q != PH_ENTRY);
        cur_len  = (ph_q == PH_FETCH) ? dec_len  : len_q;
        cur_poll = (ph_q == PH_FETCH) ? dec_poll : pollix_q;
        cur_idx  = (ph_q == PH_FETCH) ? CW'(1)   : cyc_q;
        poll_now = in_instr && (cur_idx == cur_poll);
        last_now = in_instr && (cur_idx == cur_len);
        take_now = poll_now && irq && !irq_dis && !commit_q;
    end

    // Phase, cycle index, commit and entry counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= PH_FETCH;
            cyc_q    <= CW'(1);
            len_q    <= CW'(2);
            pollix_q <= CW'(1);
            commit_q <= 1'b0;
            ent_q    <= '0;
            hnd_q    <= 1'b0;
        end else begin
            hnd_q <= 1'b0;
            if (ph_q == PH_ENTRY) begin
                if (ent_q == EW'(ENTRY_LEN)) begin
                    ph_q  <= PH_FETCH;
                    hnd_q <= 1'b1;
                end else begin
                    ent_q <= ent_q + EW'(1);
                end
            end else begin
                if (take_now)
                    commit_q <= 1'b1;
                if (last_now) begin
                    cyc_q <= CW'(1);
                    if (commit_q) begin
                        ph_q     <= PH_ENTRY;
                        ent_q    <= EW'(1);
                        commit_q <= 1'b0;
                    end else begin
                        ph_q <= PH_FETCH;
                    end
                end else begin
                    ph_q  <= PH_EXEC;
                    cyc_q <= cur_idx + CW'(1);
                    if (ph_q == PH_FETCH) begin
                        len_q    <= dec_len;
                        pollix_q <= dec_poll;
                    end
                end
            end
        end
    end

    assign ph        = ph_q;
    assign committed = commit_q || take_now;
    assign hnd_start = hnd_q;

    // A request is never taken while masked or absent.
    p_no_masked_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(commit_q) |-> ($past(irq) && !$past(irq_dis)));

    // The polling cycle is never an instruction's last cycle.
    p_poll_not_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        poll_now |-> !last_now);

    // A committed instruction end leads straight into entry.
    p_commit_enters_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_now && commit_q) |=> (ph_q == PH_ENTRY));
endmodule

// File: rtl/irqseq_lat_meter.sv
// Latency meter: counts cycles from the first cycle of a request through
// the end of the serviced instruction, holds through entry.
// Assumes: committed stays high from the take until entry begins.
module irqseq_lat_meter #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq,
    input  logic             in_entry,
    input  logic             committed,
    input  logic             hnd_start,
    output logic [LAT_W-1:0] lat
);
    logic             meas_q;
    logic [LAT_W-1:0] cnt_q;
    logic             start;

    // A measurement opens on a request seen outside entry.
    assign start = irq && !meas_q && !in_entry;

    // Measurement window and saturating cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meas_q <= 1'b0;
            cnt_q  <= '0;
        end else if (hnd_start) begin
            meas_q <= 1'b0;
        end else if (start) begin
            meas_q <= 1'b1;
            cnt_q  <= LAT_W'(1);
        end else if (meas_q && !irq && !committed && !in_entry) begin
            meas_q <= 1'b0;
        end else if (meas_q && !in_entry && (cnt_q != {LAT_W{1'b1}})) begin
            cnt_q <= cnt_q + LAT_W'(1);
        end
    end

    assign lat = cnt_q;

    // Handler entry only follows a live measurement of at least two cycles.
    p_lat_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hnd_start |-> (meas_q && (cnt_q >= LAT_W'(2))));
endmodule

// File: rtl/irq_poll_seq.sv
// Top: interrupt recognition timing sequencer. Marks each cycle as fetch,
// execute or entry, decides the polling point per instruction and reports
// request latency on the handler's first cycle.
// Assumes: the driver advances to the next descriptor after each fetch.
module irq_poll_seq
    import irqseq_pkg::*;
#(
    parameter int LEN_W     = 4,
    parameter int MAX_LEN   = irqseq_pkg::MAX_LEN,
    parameter int ENTRY_LEN = irqseq_pkg::ENTRY_CYC,
    parameter int LAT_W     = 8,
    localparam int CW       = $clog2(MAX_LEN + 1),
    localparam int RW       = $clog2(ENTRY_LEN + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] ins_len,
    input  logic             ins_branch,
    input  logic             ins_taken,
    input  logic             ins_cross,
    input  logic             irq,
    input  logic             irq_dis,
    output logic [1:0]       phase,
    output logic             poll,
    output logic             hnd_start,
    output logic [LAT_W-1:0] hnd_lat
);
    logic [CW-1:0] dec_len;
    logic [CW-1:0] dec_poll;
    phase_e        ph;
    logic          committed;

    irqseq_len_decode #(
        .LEN_W   (LEN_W),
        .MIN_LEN (irqseq_pkg::MIN_LEN),
        .MAX_LEN (MAX_LEN),
        .CW      (CW)
    ) u_dec (
        .ins_len    (ins_len),
        .ins_branch (ins_branch),
        .ins_taken  (ins_taken),
        .ins_cross  (ins_cross),
        .eff_len    (dec_len),
        .poll_idx   (dec_poll)
    );

    irqseq_cycle_ctrl #(
        .CW        (CW),
        .ENTRY_LEN (ENTRY_LEN)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_len   (dec_len),
        .dec_poll  (dec_poll),
        .irq       (irq),
        .irq_dis   (irq_dis),
        .ph        (ph),
        .poll_now  (poll),
        .committed (committed),
        .hnd_start (hnd_start)
    );

    irqseq_lat_meter #(
        .LAT_W (LAT_W)
    ) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq       (irq),
        .in_entry  (ph == PH_ENTRY),
        .committed (committed),
        .hnd_start (hnd_start),
        .lat       (hnd_lat)
    );

    assign phase = ph;

    // Checker-only run length of consecutive entry cycles.
    logic [RW-1:0] ent_run;
    always_ff @(posedge clk) begin
        if (!rst_n)
            ent_run <= '0;
        else if (phase == PH_ENTRY)
            ent_run <= ent_run + RW'(1);
        else
            ent_run <= '0;
    end

    // Handler start comes right after a full entry run.
    p_entry_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hnd_start |-> (ent_run == RW'(ENTRY_LEN)));

    // The handler strobe is a single cycle.
    p_hnd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hnd_start |=> !hnd_start);

    // An in-page taken branch polls in its first cycle and never after.
    p_branch_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH && ins_branch && ins_taken && !ins_cross)
            |-> poll ##1 (!poll) ##1 (!poll));
endmodule

// File: tb/irq_poll_seq_tb.sv
`timescale 1ns/1ps
module irq_poll_seq_tb_top;
    localparam int MAXC = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ins_len;
    logic       ins_branch, ins_taken, ins_cross;
    logic       irq = 1'b0;
    logic       irq_dis = 1'b0;
    logic [1:0] phase;
    logic       poll;
    logic       hnd_start;
    logic [7:0] hnd_lat;

    // Descriptor encoding: {branch, taken, cross, len[3:0]}.
    logic [6:0] prog [4];
    int         plen = 1;
    int         idx = 0;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    int         ph_exp [MAXC];
    bit         pl_exp [MAXC];

    always #10 clk = ~clk;

    irq_poll_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ins_len(ins_len), .ins_branch(ins_branch),
        .ins_taken(ins_taken), .ins_cross(ins_cross), .irq(irq),
        .irq_dis(irq_dis), .phase(phase), .poll(poll),
        .hnd_start(hnd_start), .hnd_lat(hnd_lat)
    );

    always_comb {ins_branch, ins_taken, ins_cross, ins_len} = prog[idx % plen];

    // Next descriptor after each fetch cycle.
    always @(posedge clk) begin
        if (!rst_n) idx <= 0;
        else if (phase == 2'd0) idx <= idx + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Length and poll index from R3/R4/R5.
    function automatic void dec(input logic [6:0] d, output int len, output int p);
        if (d[6]) begin
            if (!d[5]) begin len = 2; p = 1; end
            else if (!d[4]) begin len = 3; p = 1; end
            else begin len = 4; p = 3; end
        end else begin
            len = (d[3:0] < 2) ? 2 : (d[3:0] > 8) ? 8 : int'(d[3:0]);
            p = len - 1;
        end
    endfunction

    // One trial: reset, request rising at cycle d, optional early drop,
    // optional earlier withdrawn pulse, optional disable window.
    task automatic trial(input int d, input int drop_at, input int pre_on,
                         input int pre_off, input int dis_from, input int dis_to);
        int s, i, len, p, pc, lat, h, exp_lat;
        bit found, seen_entry, got;
        s = 0; i = 0; found = 0; lat = 0;
        while (!found) begin
            dec(prog[i % plen], len, p);
            for (int j = 0; j < len; j++) begin
                ph_exp[s+j] = (j == 0) ? 0 : 1;
                pl_exp[s+j] = (j == p - 1);
            end
            pc = s + p - 1;
            if (pc >= d && !(pc >= dis_from && pc < dis_to)) begin
                found = 1; lat = s + len - d;
            end
            s += len; i++;
        end
        for (int k = 0; k < 7; k++) begin ph_exp[s+k] = 2; pl_exp[s+k] = 0; end
        h = s + 7;
        dec(prog[i % plen], len, p);
        ph_exp[h] = 0; pl_exp[h] = (p == 1);
        exp_lat = (lat > 255) ? 255 : lat;

        @(negedge clk); rst_n = 0; irq = 0; irq_dis = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        seen_entry = 0; got = 0;
        for (int c = 0; c <= h + 20; c++) begin
            irq = (c >= d && (drop_at < 0 ? !seen_entry : c < drop_at)) ||
                  (c >= pre_on && c < pre_off);
            irq_dis = (c >= dis_from && c < dis_to);
            #1;
            if (c == 0) begin
                chk(phase == 2'd0, "R1 phase", int'(phase), 0);
                chk(hnd_start == 1'b0, "R1 hnd_start", int'(hnd_start), 0);
            end
            if (c <= h) begin
                chk(int'(phase) == ph_exp[c], "R2/R3/R7 phase", int'(phase), ph_exp[c]);
                chk(poll == pl_exp[c], "R4/R5 poll", int'(poll), int'(pl_exp[c]));
            end
            if (hnd_start) begin
                chk(c == h, "R6/R7/R9/R10 handler cycle", c, h);
                chk(int'(hnd_lat) == exp_lat, "R8 latency", int'(hnd_lat), exp_lat);
                got = 1;
                break;
            end
            if (phase == 2'd2) seen_entry = 1;
            @(negedge clk);
        end
        chk(got, "R7 handler reached", int'(got), 1);
        irq = 0; irq_dis = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c0ffee));
        // R6: back-to-back 2-cycle instructions give 2 or 3.
        plen = 1; prog[0] = 7'h02;
        trial(4, -1, -1, -1, 0, 0);           // on poll: lat 2
        trial(5, -1, -1, -1, 0, 0);           // last cycle: lat 3
        // R5: 7-cycle op plus in-page taken branch.
        plen = 2; prog[0] = 7'h07; prog[1] = 7'h60;
        trial(7, -1, -1, -1, 0, 0);           // lat 3
        trial(8, -1, -1, -1, 0, 0);           // branch cycle 2: lat 9
        trial(9, -1, -1, -1, 0, 0);           // lat 8
        trial(6, -1, -1, -1, 0, 0);           // lat 4
        // R4: page-crossing taken branch polls normally, no 10.
        plen = 2; prog[0] = 7'h07; prog[1] = 7'h70;
        trial(8, -1, -1, -1, 0, 0);           // lat 3
        trial(10, -1, -1, -1, 0, 0);          // lat 8
        // R3: 8-cycle op and clamping of 0 and 15.
        plen = 1; prog[0] = 7'h08;
        trial(0, -1, -1, -1, 0, 0);           // lat 8
        plen = 2; prog[0] = 7'h00; prog[1] = 7'h0F;
        trial(1, -1, -1, -1, 0, 0);
        trial(3, -1, -1, -1, 0, 0);
        // R4: not-taken branch polls in cycle 1.
        plen = 2; prog[0] = 7'h40; prog[1] = 7'h03;
        trial(1, -1, -1, -1, 0, 0);           // lat 4
        // R9: masked until cycle 20, then taken; saturation of R8.
        plen = 1; prog[0] = 7'h02;
        trial(2, -1, -1, -1, 0, 20);          // lat 20
        trial(2, -1, -1, -1, 0, 400);         // lat saturates at 255
        // R10: withdrawn pulse then fresh request; drop after take.
        trial(10, -1, 3, 4, 0, 0);            // lat 2
        plen = 1; prog[0] = 7'h07;
        trial(5, 6, -1, -1, 0, 0);            // lat 2
        // Random programs, rises and disable windows.
        for (int t = 0; t < 40; t++) begin
            int d, df, dt;
            plen = 1 + int'($urandom_range(3));
            for (int k = 0; k < 4; k++) begin
                if ($urandom_range(9) < 3)
                    prog[k] = {1'b1, 1'($urandom_range(1)), 1'($urandom_range(1)), 4'h0};
                else
                    prog[k] = {3'b000, 4'($urandom_range(15))};
            end
            d = int'($urandom_range(40));
            if ($urandom_range(1) == 1) begin
                df = d + int'($urandom_range(6)) - 3;
                dt = df + 1 + int'($urandom_range(29));
            end else begin
                df = 0; dt = 0;
            end
            trial(d, -1, -1, -1, df, dt);
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule